// File: doc/BRIEF.md
# Lane Mask Stack for Divergent Thread Groups

This block tracks which lanes of a 32-lane lockstep thread group are enabled while the group runs through nested, data-dependent branches. Each lane supplies one predicate bit, produced by an earlier compare. When a branch diverges, the sequencer raises a push strobe. The block then saves the enabled-lane mask, together with the predicate, in an internal LIFO. The new enabled set becomes the old mask ANDed with the predicate.

At the else point, a complement strobe enables the other side of the branch. That set is the saved mask ANDed with the inverse of the saved predicate. At the join point, a pop strobe restores the saved mask and removes the entry. The block reports the current depth. It also has sticky flags for a push into a full stack and for a pop or complement with nothing saved, plus a flag that marks a freshly entered path with no enabled lane, so that a sequencer may skip that path. The group is executed over half as many physical lanes in two beats per instruction. The mask covers the full group width, and each instruction issue uses it unchanged for both beats.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the enabled mask is all ones, the depth is 0 and the overflow, underflow and empty-path flags are all 0.
- R2: A push with depth below the limit makes the mask (old mask AND predicate), increments the depth by one and saves the old mask and the predicate.
- R3: A complement with depth at least 1 makes the mask (saved mask AND NOT saved predicate) from the top entry and leaves the depth unchanged.
- R4: A pop with depth at least 1 restores the mask saved by the matching push and decrements the depth by one.
- R5: Entries nest in last-in first-out order up to the stack limit (parameter, default 8), and the depth never exceeds that limit.
- R6: A push at the limit leaves the mask, depth and stack unchanged and sets the overflow flag, which stays 1 until reset.
- R7: A pop or complement at depth 0 leaves the mask and depth unchanged and sets the underflow flag, which stays 1 until reset.
- R8: After an accepted push or complement, the empty-path flag is 1 exactly when the resulting mask is all zeros. An accepted pop clears it. Cycles with no accepted command leave it unchanged.
- R9: When more than one strobe is high in a cycle, only one command acts, with priority push over complement over pop.
- R10: Every output is registered. The effect of a strobe sampled at a rising edge is visible immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Divergent-branch strobe |
| comp_i | input | 1 | Else-path strobe |
| pop_i | input | 1 | Join strobe |
| pred_i | input | LANES | Per-lane predicate, bit n for lane n |
| mask_o | output | LANES | Enabled-lane mask |
| depth_o | output | $clog2(DEPTH+1) | Number of saved entries |
| overflow_o | output | 1 | Sticky push-into-full flag |
| underflow_o | output | 1 | Sticky pop/complement-when-empty flag |
| path_empty_o | output | 1 | Most recent entered path has no enabled lane |

## Verification
Each output responds one cycle after its strobe. A command sampled at a rising edge shows its mask, depth and flags right after that same edge, and pred_i is read only at that edge. The bench drives the strobes and the predicate on the falling edge, lets one rising edge pass, and compares all outputs on the next falling edge. In that way every check falls exactly one register stage after its stimulus. For the full, empty and sticky cases, the bench samples after the offending strobe and again after a later legal command, which shows that the state was held and that the flags did not clear.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_COMP = 2'd2,
        CMD_POP  = 2'd3
    } cmd_e;
endpackage

// File: rtl/simt_cmd_prio.sv
module simt_cmd_prio
    import simt_mask_pkg::*;
(
    input  logic push_i,
    input  logic comp_i,
    input  logic pop_i,
    output cmd_e cmd_o
);
    // push outranks complement, complement outranks pop (R9)
    always_comb begin
        if (push_i)      cmd_o = CMD_PUSH;
        else if (comp_i) cmd_o = CMD_COMP;
        else if (pop_i)  cmd_o = CMD_POP;
        else             cmd_o = CMD_IDLE;
    end
endmodule

// File: rtl/simt_mask_store.sv
module simt_mask_store #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [LANES-1:0] wr_mask,
    input  logic [LANES-1:0] wr_pred,
    input  logic [IW-1:0]    rd_idx,
    output logic [LANES-1:0] rd_mask,
    output logic [LANES-1:0] rd_pred
);
    logic [LANES-1:0] mask_q [DEPTH];
    logic [LANES-1:0] pred_q [DEPTH];
    logic [DEPTH-1:0] slot_we;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_we[g] = wr_en && (wr_idx == IW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mask_q[i] <= '0;
                pred_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (slot_we[i]) begin
                    mask_q[i] <= wr_mask;
                    pred_q[i] <= wr_pred;
                end
            end
        end
    end

    assign rd_mask = mask_q[rd_idx];
    assign rd_pred = pred_q[rd_idx];
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             comp_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] pred_i,
    output logic [LANES-1:0] mask_o,
    output logic [DW-1:0]    depth_o,
    output logic             overflow_o,
    output logic             underflow_o,
    output logic             path_empty_o
);
    localparam logic [DW-1:0] FULL = DW'(DEPTH);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [DW-1:0]    depth;
        logic             ovf;
        logic             udf;
        logic             pe;
    } state_t;

    localparam state_t RST = '{mask: '1, depth: '0, ovf: 1'b0, udf: 1'b0, pe: 1'b0};

    state_t           st_d, st_q;
    cmd_e             cmd;
    logic             wr_en;
    logic [IW-1:0]    wr_idx, rd_idx;
    logic [LANES-1:0] top_mask, top_pred;
    logic [LANES-1:0] narrowed, other_side;
    logic [DW-1:0]    below;

    simt_cmd_prio u_prio (
        .push_i (push_i),
        .comp_i (comp_i),
        .pop_i  (pop_i),
        .cmd_o  (cmd)
    );

    simt_mask_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_mask (st_q.mask),
        .wr_pred (pred_i),
        .rd_idx  (rd_idx),
        .rd_mask (top_mask),
        .rd_pred (top_pred)
    );

    always_comb begin
        st_d       = st_q;
        wr_en      = 1'b0;
        below      = st_q.depth - DW'(1);
        wr_idx     = st_q.depth[IW-1:0];
        rd_idx     = below[IW-1:0];
        narrowed   = st_q.mask & pred_i;
        other_side = top_mask & ~top_pred;
        unique case (cmd)
            CMD_PUSH: begin
                if (st_q.depth == FULL) begin
                    st_d.ovf = 1'b1;
                end else begin
                    wr_en      = 1'b1;
                    st_d.mask  = narrowed;
                    st_d.depth = st_q.depth + DW'(1);
                    st_d.pe    = (narrowed == '0);
                end
            end
            CMD_COMP: begin
                if (st_q.depth == '0) begin
                    st_d.udf = 1'b1;
                end else begin
                    st_d.mask = other_side;
                    st_d.pe   = (other_side == '0);
                end
            end
            CMD_POP: begin
                if (st_q.depth == '0) begin
                    st_d.udf = 1'b1;
                end else begin
                    st_d.mask  = top_mask;
                    st_d.depth = below;
                    st_d.pe    = 1'b0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign mask_o       = st_q.mask;
    assign depth_o      = st_q.depth;
    assign overflow_o   = st_q.ovf;
    assign underflow_o  = st_q.udf;
    assign path_empty_o = st_q.pe;

    AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PUSH && depth_o != FULL) |=> depth_o == $past(depth_o) + DW'(1)); // R2
    AST_PUSH_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PUSH && depth_o != FULL) |=> (mask_o & ~$past(mask_o)) == '0); // R2
    AST_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_POP && depth_o != '0) |=> mask_o == $past(top_mask)); // R4
    AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= FULL); // R5
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PUSH && depth_o == FULL) |=> overflow_o && $stable(mask_o) && $stable(depth_o)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R6
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_POP || cmd == CMD_COMP) && depth_o == '0) |=> underflow_o && $stable(mask_o)); // R7
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |=> underflow_o); // R7
endmodule

// File: tb/simt_mask_stack_tb.sv
module simt_mask_stack_tb;
    localparam int LANES = 32;
    localparam int DEPTH = 8;
    localparam int DW = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push_i = 1'b0, comp_i = 1'b0, pop_i = 1'b0;
    logic [LANES-1:0] pred_i = '0;
    logic [LANES-1:0] mask_o;
    logic [DW-1:0]    depth_o;
    logic             overflow_o, underflow_o, path_empty_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .comp_i(comp_i), .pop_i(pop_i),
        .pred_i(pred_i), .mask_o(mask_o), .depth_o(depth_o), .overflow_o(overflow_o),
        .underflow_o(underflow_o), .path_empty_o(path_empty_o)
    );

    typedef struct packed {
        logic        pu, co, po;
        logic [31:0] pred;
        logic [31:0] em;
        logic [3:0]  ed;
        logic        epe;
    } vec_t;

    // R2 R3 R4 R5 R8 R9 R10: walk through nested branches and simultaneous strobes
    localparam vec_t VECS [15] = '{
        '{1'b1,1'b0,1'b0, 32'h0000FFFF, 32'h0000FFFF, 4'd1, 1'b0},
        '{1'b1,1'b0,1'b0, 32'h00FF00FF, 32'h000000FF, 4'd2, 1'b0},
        '{1'b0,1'b1,1'b0, 32'h00000000, 32'h0000FF00, 4'd2, 1'b0},
        '{1'b1,1'b0,1'b0, 32'h00000F00, 32'h00000F00, 4'd3, 1'b0},
        '{1'b0,1'b1,1'b0, 32'h00000000, 32'h0000F000, 4'd3, 1'b0},
        '{1'b0,1'b0,1'b1, 32'h00000000, 32'h0000FF00, 4'd2, 1'b0},
        '{1'b1,1'b0,1'b0, 32'h000000FF, 32'h00000000, 4'd3, 1'b1},
        '{1'b0,1'b1,1'b0, 32'h00000000, 32'h0000FF00, 4'd3, 1'b0},
        '{1'b0,1'b0,1'b1, 32'h00000000, 32'h0000FF00, 4'd2, 1'b0},
        '{1'b0,1'b0,1'b1, 32'h00000000, 32'h0000FFFF, 4'd1, 1'b0},
        '{1'b0,1'b0,1'b1, 32'h00000000, 32'hFFFFFFFF, 4'd0, 1'b0},
        '{1'b1,1'b1,1'b1, 32'hF0F0F0F0, 32'hF0F0F0F0, 4'd1, 1'b0},
        '{1'b0,1'b1,1'b1, 32'h00000000, 32'h0F0F0F0F, 4'd1, 1'b0},
        '{1'b0,1'b0,1'b1, 32'h00000000, 32'hFFFFFFFF, 4'd0, 1'b0},
        '{1'b0,1'b0,1'b0, 32'hDEADBEEF, 32'hFFFFFFFF, 4'd0, 1'b0}
    };

    task automatic check(input string req, input logic [LANES-1:0] em, input int ed,
                         input logic eo, input logic eu, input logic epe);
        total++;
        if (mask_o !== em || int'(depth_o) != ed || overflow_o !== eo ||
            underflow_o !== eu || path_empty_o !== epe) begin
            bad++;
            $display("FAIL %s: got mask=%h depth=%0d ovf=%b udf=%b pe=%b, want mask=%h depth=%0d ovf=%b udf=%b pe=%b",
                     req, mask_o, depth_o, overflow_o, underflow_o, path_empty_o,
                     em, ed, eo, eu, epe);
        end
    endtask

    // drive on falling edge, one rising edge acts, sample on next falling edge (R10)
    task automatic step(input logic pu, input logic co, input logic po, input logic [LANES-1:0] p);
        push_i = pu; comp_i = co; pop_i = po; pred_i = p;
        @(negedge clk);
        push_i = 1'b0; comp_i = 1'b0; pop_i = 1'b0; pred_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset", '1, 0, 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < 15; i++) begin
            step(VECS[i].pu, VECS[i].co, VECS[i].po, VECS[i].pred);
            check($sformatf("R2/R3/R4/R8/R9 vector %0d", i), VECS[i].em, int'(VECS[i].ed),
                  1'b0, 1'b0, VECS[i].epe);
        end

        // R5 fill to the limit with distinct predicates, then unwind in LIFO order
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 1'b0, ~(32'h1 << i));
        end
        check("R5 full depth", ~32'h000000FF, DEPTH, 1'b0, 1'b0, 1'b0);
        // R6 push when full is refused, overflow sticks
        step(1'b1, 1'b0, 1'b0, 32'h0);
        check("R6 push when full", ~32'h000000FF, DEPTH, 1'b1, 1'b0, 1'b0);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(1'b0, 1'b0, 1'b1, '0);
            check("R5 lifo unwind", ~((32'h1 << i) - 32'h1), i, 1'b1, 1'b0, 1'b0);
        end
        // R7 pop at depth 0
        step(1'b0, 1'b0, 1'b1, '0);
        check("R7 pop when empty", '1, 0, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 32'h0000000F);
        check("R6 R7 flags sticky after push", 32'h0000000F, 1, 1'b1, 1'b1, 1'b0);

        // R7 complement at depth 0 after fresh reset
        do_reset();
        check("R1 reset again", '1, 0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, 32'h12345678);
        check("R7 complement when empty", '1, 0, 1'b0, 1'b1, 1'b0);

        // R8 empty-path flag from a complement; idle leaves it set
        step(1'b1, 1'b0, 1'b0, 32'hFFFFFFFF);
        check("R8 push all lanes", '1, 1, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, '0);
        check("R8 complement empty", 32'h0, 1, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0, 32'hFFFF0000);
        check("R8 idle holds", 32'h0, 1, 1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1, '0);
        check("R8 pop clears", '1, 0, 1'b0, 1'b1, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule